// File: doc/BRIEF.md
# Command Queue Trigger Status Controller

This block runs one command queue channel that hands conversion commands to a converter. It follows the channel through three states (idle, waiting for a trigger, triggered). It passes one queued command word across to the converter on each handshake, but only while the channel is triggered. Each command word carries a pause bit and an end-of-queue bit, and the block reacts to them according to the trigger mode in use.

Three trigger sources are supported: software, a trigger edge and a trigger level (gate). Each of them runs in single-scan form, which needs an arm request per scan, or in continuous-scan form. The block keeps three sticky status flags: pause, end-of-queue and trigger overrun. Writing a one to a flag's clear bit clears it. Each flag raises an interrupt request when its enable is high.

The external trigger passes through a two-flop synchronizer. One polarity input picks both the active edge and the open level of the gate.

Top module: `cmdq_trig_ctrl`

## Requirements
- R1: While reset is high the channel state is IDLE (code 0), all three flags and all three interrupt requests are low, and `cmd_ready` is low.
- R2: State codes are IDLE=0, WAIT=1 and TRIGGERED=2. Mode codes are off=0, software=1, edge=2 and level=3. With a mode other than off, an IDLE channel moves to WAIT when continuous scan is selected or the channel is armed. Mode off forces IDLE. A software-mode WAIT becomes TRIGGERED on the next cycle. `cmd_ready` can be high only in TRIGGERED. A command transfers in any cycle where `cmd_valid` and `cmd_ready` are both high, and `conv_cmd` then equals `cmd_word`.
- R3: The trigger input is synchronized through two flops. With `cfg_pol_rise`=1 a rising edge is the trigger and the gate is open when the input is high. With `cfg_pol_rise`=0 a falling edge is the trigger and the gate is open when the input is low. In edge mode a trigger moves WAIT to TRIGGERED.
- R4: In edge mode (single or continuous), transferring a command whose pause bit (bit 30) is set moves the channel to WAIT and sets the pause flag (flags bit 0). The armed state is left set. The next trigger edge returns the channel to TRIGGERED and transfers resume.
- R5: In software and level modes the pause bit is ignored: the channel stays TRIGGERED and the pause flag is not set by it.
- R6: In level mode, if the gate is closed while the channel is TRIGGERED, the channel moves to WAIT on the next clock and the pause flag is set. No command transfers in that cycle.
- R7: In edge mode, a trigger edge that arrives while the channel is TRIGGERED sets the overrun flag (flags bit 2). Level mode never sets the overrun flag.
- R8: Transferring a command whose end-of-queue bit (bit 31) is set sets the end-of-queue flag (flags bit 1) at once. In single scan the channel then goes to IDLE and the armed state clears. In continuous scan it goes to WAIT.
- R9: Flags are sticky. A one in `flag_clr` clears the matching flag. A set event in the same cycle as a clear leaves the flag set.
- R10: Each bit of `irq` is high exactly when the matching flag and the matching `irq_en` bit are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Trigger mode: 0 off, 1 software, 2 edge, 3 level |
| cfg_cont | input | 1 | 1 selects continuous scan, 0 selects single scan |
| cfg_pol_rise | input | 1 | 1: rising edge / high gate; 0: falling edge / low gate |
| arm_req | input | 1 | Single-cycle pulse that arms a single scan |
| trig_in | input | 1 | Asynchronous external trigger or gate |
| cmd_valid | input | 1 | Queue has a command word |
| cmd_word | input | CMD_W | Command word; bit 31 end-of-queue, bit 30 pause |
| cmd_ready | output | 1 | Channel accepts the command word this cycle |
| conv_ready | input | 1 | Converter can accept a command |
| conv_valid | output | 1 | Command presented to the converter |
| conv_cmd | output | CMD_W | Command word to the converter |
| irq_en | input | 3 | Interrupt enables: bit 0 pause, bit 1 end-of-queue, bit 2 overrun |
| flag_clr | input | 3 | Write-one-to-clear strobes, same bit order as flags |
| flags | output | 3 | Sticky flags: bit 0 pause, bit 1 end-of-queue, bit 2 overrun |
| irq | output | 3 | Interrupt requests, same bit order |
| chan_state | output | 2 | Channel state: 0 IDLE, 1 WAIT, 2 TRIGGERED |
| scan_armed | output | 1 | Single-scan armed state |

## Verification
One command word is sent under each pairing of trigger mode (software, edge, level) and scan form. Each word carries the pause bit, the end-of-queue bit, both bits, or neither. The state that follows shows how each bit is handled: a pause that returns the channel to WAIT only in edge mode, and an end of queue that goes to IDLE for single scan but to WAIT for continuous scan. Directed sequences then cover:
- resuming with a fresh edge after a pause;
- closing the gate in level mode;
- a second edge while triggered, in edge mode versus level mode;
- falling-edge polarity;
- a clear landing in the same cycle as a set;
- interrupt enable gating.

// File: rtl/cqt_pkg.sv
package cqt_pkg;

    typedef enum logic [1:0] {
        TM_OFF   = 2'd0,
        TM_SW    = 2'd1,
        TM_EDGE  = 2'd2,
        TM_LEVEL = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_WAIT = 2'd1,
        CH_TRIG = 2'd2
    } chan_state_e;

    localparam int NUM_FLAGS  = 3;
    localparam int FLAG_PAUSE = 0;
    localparam int FLAG_EOQ   = 1;
    localparam int FLAG_OVR   = 2;

    // Bit order matches FLAG_* positions: ovr is the MSB, pause the LSB.
    typedef struct packed {
        logic ovr;
        logic eoq;
        logic pause;
    } flag_set_t;

    function automatic logic honours_pause(trig_mode_e m);
        return m == TM_EDGE;
    endfunction

endpackage

// File: rtl/cqt_trig_sync.sv
module cqt_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_async,
    input  logic pol_rise,
    output logic gate_open,
    output logic trig_edge
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          prev;
    logic          lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[LAST-1:0], trig_async};
            prev  <= chain[LAST];
        end
    end

    assign lvl       = chain[LAST];
    assign gate_open = pol_rise ? lvl : !lvl;
    assign trig_edge = pol_rise ? (lvl && !prev) : (!lvl && prev);

    // R3: a detected edge is a single-cycle event while polarity holds
    p_edge_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        trig_edge |=> (!trig_edge || !$stable(pol_rise)));

endmodule

// File: rtl/cqt_chan_fsm.sv
module cqt_chan_fsm
    import cqt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  trig_mode_e  mode,
    input  logic        cont,
    input  logic        arm_req,
    input  logic        trig_edge,
    input  logic        gate_open,
    input  logic        cmd_valid,
    input  logic        conv_ready,
    input  logic        cmd_pause,
    input  logic        cmd_eoq,
    output chan_state_e state,
    output logic        armed,
    output logic        xfer_ready,
    output flag_set_t   evt
);
    chan_state_e state_d;
    logic        armed_d;
    logic        xfer;
    logic        gate_close;
    logic        pause_hit;
    logic        eoq_hit;
    logic        in_trig;

    assign in_trig    = (state == CH_TRIG);
    assign gate_close = (mode == TM_LEVEL) && in_trig && !gate_open;
    assign xfer_ready = in_trig && conv_ready && !gate_close;
    assign xfer       = xfer_ready && cmd_valid;
    assign pause_hit  = xfer && cmd_pause && honours_pause(mode);
    assign eoq_hit    = xfer && cmd_eoq;

    always_comb begin
        evt.pause = pause_hit || gate_close;
        evt.eoq   = eoq_hit;
        evt.ovr   = (mode == TM_EDGE) && in_trig && trig_edge;
    end

    always_comb begin
        state_d = state;
        if (mode == TM_OFF) begin
            state_d = CH_IDLE;
        end else begin
            unique case (state)
                CH_IDLE: if (cont || armed) state_d = CH_WAIT;
                CH_WAIT: begin
                    unique case (mode)
                        TM_SW:    state_d = CH_TRIG;
                        TM_EDGE:  if (trig_edge) state_d = CH_TRIG;
                        TM_LEVEL: if (gate_open) state_d = CH_TRIG;
                        default:  state_d = CH_IDLE;
                    endcase
                end
                CH_TRIG: begin
                    if (eoq_hit)
                        state_d = cont ? CH_WAIT : CH_IDLE;
                    else if (pause_hit || gate_close)
                        state_d = CH_WAIT;
                end
                default: state_d = CH_IDLE;
            endcase
        end
    end

    always_comb begin
        armed_d = armed;
        if (arm_req)
            armed_d = 1'b1;
        else if (eoq_hit && !cont)
            armed_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CH_IDLE;
            armed <= 1'b0;
        end else begin
            state <= state_d;
            armed <= armed_d;
        end
    end

    // R3: an edge seen while waiting in edge mode starts the scan
    p_wait_edge_r3: assert property (@(posedge clk) disable iff (rst)
        (state == CH_WAIT && mode == TM_EDGE && trig_edge) |=> state == CH_TRIG);

    // R4: a pause in edge mode parks the channel and keeps it armed
    p_pause_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (pause_hit && !eoq_hit) |=> (state == CH_WAIT && (!$past(armed) || armed)));

    // R5: software mode keeps running through a pause bit
    p_sw_pause_r5: assert property (@(posedge clk) disable iff (rst)
        (xfer && mode == TM_SW && cmd_pause && !cmd_eoq) |=> state == CH_TRIG);

    // R6: a closed gate leaves TRIGGERED on the next clock
    p_gate_close_r6: assert property (@(posedge clk) disable iff (rst)
        gate_close |=> state == CH_WAIT);

    // R8: a single scan ends in IDLE and disarms
    p_single_eoq_r8: assert property (@(posedge clk) disable iff (rst)
        (eoq_hit && !cont && !arm_req) |=> (state == CH_IDLE && !armed));

endmodule

// File: rtl/cqt_status_flags.sv
module cqt_status_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_evt,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ie,
    output logic [N-1:0] flags_q,
    output logic [N-1:0] irq
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags_q[i] <= 1'b0;
            else if (set_evt[i])
                flags_q[i] <= 1'b1;
            else if (clr[i])
                flags_q[i] <= 1'b0;
        end

        assign irq[i] = flags_q[i] && ie[i];

        // R9: a set event wins, even against a clear
        p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
            set_evt[i] |=> flags_q[i]);

        // R9: a clear without a set drops the flag
        p_w1c_r9: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !set_evt[i]) |=> !flags_q[i]);

        // R9: a flag holds until cleared
        p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
            (flags_q[i] && !clr[i]) |=> flags_q[i]);
    end

endmodule

// File: rtl/cmdq_trig_ctrl.sv
module cmdq_trig_ctrl
    import cqt_pkg::*;
#(
    parameter int CMD_W       = 32,
    parameter int PAUSE_BIT   = 30,
    parameter int EOQ_BIT     = 31,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_cont,
    input  logic             cfg_pol_rise,
    input  logic             arm_req,
    input  logic             trig_in,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             cmd_ready,
    input  logic             conv_ready,
    output logic             conv_valid,
    output logic [CMD_W-1:0] conv_cmd,
    input  logic [2:0]       irq_en,
    input  logic [2:0]       flag_clr,
    output logic [2:0]       flags,
    output logic [2:0]       irq,
    output logic [1:0]       chan_state,
    output logic             scan_armed
);
    localparam int NF = NUM_FLAGS;

    trig_mode_e  mode;
    chan_state_e state;
    flag_set_t   evt;
    logic        gate_open;
    logic        trig_edge;
    logic        ready;

    assign mode = trig_mode_e'(cfg_mode);

    cqt_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .trig_async (trig_in),
        .pol_rise   (cfg_pol_rise),
        .gate_open  (gate_open),
        .trig_edge  (trig_edge)
    );

    cqt_chan_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .cont       (cfg_cont),
        .arm_req    (arm_req),
        .trig_edge  (trig_edge),
        .gate_open  (gate_open),
        .cmd_valid  (cmd_valid),
        .conv_ready (conv_ready),
        .cmd_pause  (cmd_word[PAUSE_BIT]),
        .cmd_eoq    (cmd_word[EOQ_BIT]),
        .state      (state),
        .armed      (scan_armed),
        .xfer_ready (ready),
        .evt        (evt)
    );

    cqt_status_flags #(.N(NF)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_evt (evt),
        .clr     (flag_clr),
        .ie      (irq_en),
        .flags_q (flags),
        .irq     (irq)
    );

    assign cmd_ready  = ready;
    assign conv_valid = ready && cmd_valid;
    assign conv_cmd   = cmd_word;
    assign chan_state = state;

    // R2: the queue is only drained in the TRIGGERED state
    p_ready_trig_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> chan_state == CH_TRIG);

    // R7: level mode never raises the overrun flag
    p_level_no_ovr_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == TM_LEVEL && !flags[FLAG_OVR]) |=> !flags[FLAG_OVR]);

endmodule

// File: tb/cmdq_trig_ctrl_bench.sv
`timescale 1ns/1ps
module cmdq_trig_ctrl_bench;

    typedef struct packed {
        logic [1:0] mode;
        logic       cont;
        logic       pb;
        logic       eb;
        logic [1:0] st;
        logic       pf;
        logic       ef;
        logic       arm;
    } row_t;

    // mode, cont, pause bit, eoq bit -> state, pause flag, eoq flag, armed
    localparam row_t ROWS [10] = '{
        '{2'd1, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1},
        '{2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0},
        '{2'd1, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1},
        '{2'd2, 1'b0, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1},
        '{2'd2, 1'b1, 1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1},
        '{2'd2, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0},
        '{2'd3, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1},
        '{2'd3, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 1'b1},
        '{2'd2, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1},
        '{2'd3, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_cont = 1'b0;
    logic        cfg_pol_rise = 1'b1;
    logic        arm_req = 1'b0;
    logic        trig_in = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic        cmd_ready;
    logic        conv_ready = 1'b1;
    logic        conv_valid;
    logic [31:0] conv_cmd;
    logic [2:0]  irq_en = 3'b000;
    logic [2:0]  flag_clr = 3'b000;
    logic [2:0]  flags;
    logic [2:0]  irq;
    logic [1:0]  chan_state;
    logic        scan_armed;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cmdq_trig_ctrl u_cmdq_trig_ctrl (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_cont(cfg_cont),
        .cfg_pol_rise(cfg_pol_rise), .arm_req(arm_req), .trig_in(trig_in),
        .cmd_valid(cmd_valid), .cmd_word(cmd_word), .cmd_ready(cmd_ready),
        .conv_ready(conv_ready), .conv_valid(conv_valid), .conv_cmd(conv_cmd),
        .irq_en(irq_en), .flag_clr(flag_clr), .flags(flags), .irq(irq),
        .chan_state(chan_state), .scan_armed(scan_armed)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input logic [1:0] m, input logic c, input logic pol, input logic idle);
        @(negedge clk);
        rst = 1'b1; cfg_mode = m; cfg_cont = c; cfg_pol_rise = pol;
        trig_in = idle; cmd_valid = 1'b0; flag_clr = 3'b000; arm_req = 1'b0;
        cyc(2);
        rst = 1'b0; arm_req = 1'b1;
        cyc(1);
        arm_req = 1'b0;
    endtask

    // Called at a negedge; returns at the negedge after the transfer edge.
    task automatic send(input logic pb, input logic eb, input logic [11:0] data);
        cmd_word = {eb, pb, 18'd0, data};
        cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cfg_mode = 2'd1; cfg_cont = 1'b1; cmd_valid = 1'b1; irq_en = 3'b111;
        cyc(3);
        chk("R1 state", chan_state, 0);
        chk("R1 flags", flags, 0);
        chk("R1 irq", irq, 0);
        chk("R1 cmd_ready", cmd_ready, 0);
        cmd_valid = 1'b0; irq_en = 3'b000;

        // Table: one command per mode and scan form (R2 R4 R5 R8)
        foreach (ROWS[i]) begin
            start(ROWS[i].mode, ROWS[i].cont, 1'b1, 1'b0);
            if (ROWS[i].mode != 2'd1) trig_in = 1'b1;
            cyc(6);
            chk("R2 triggered", chan_state, 2);
            cmd_word = {ROWS[i].eb, ROWS[i].pb, 18'd0, 12'(i + 12'h5A0)};
            cmd_valid = 1'b1;
            #1;
            chk("R2 conv_valid", conv_valid, 1);
            chk("R2 conv_cmd", conv_cmd, cmd_word);
            @(posedge clk);
            @(negedge clk);
            cmd_valid = 1'b0;
            #1;
            chk(ROWS[i].pb && ROWS[i].mode != 2'd2 ? "R5 state" : "R4 R8 state",
                chan_state, ROWS[i].st);
            chk("R4 R5 pause flag", flags[0], ROWS[i].pf);
            chk("R8 eoq flag", flags[1], ROWS[i].ef);
            chk("R7 no overrun", flags[2], 0);
            chk("R8 armed", scan_armed, ROWS[i].arm);
        end

        // R4: resume after pause with next edge
        start(2'd2, 1'b1, 1'b1, 1'b0);
        trig_in = 1'b1; cyc(6);
        send(1'b1, 1'b0, 12'h111);
        chk("R4 paused", chan_state, 1);
        trig_in = 1'b0; cyc(4);
        chk("R4 stays paused", chan_state, 1);
        trig_in = 1'b1; cyc(5);
        chk("R4 resumed", chan_state, 2);
        cmd_word = {2'b00, 18'd0, 12'h123}; cmd_valid = 1'b1; #1;
        chk("R4 resume transfer", {conv_valid, conv_cmd[11:0]}, {1'b1, 12'h123});
        cmd_valid = 1'b0;

        // R9: set and clear in the same cycle, then clear alone
        @(negedge clk);
        flag_clr = 3'b001;
        send(1'b1, 1'b0, 12'h222);
        flag_clr = 3'b000;
        chk("R9 set wins", flags[0], 1);
        flag_clr = 3'b001; cyc(1); flag_clr = 3'b000;
        chk("R9 cleared", flags[0], 0);

        // R7 R10: overrun in edge mode
        start(2'd2, 1'b0, 1'b1, 1'b0);
        irq_en = 3'b100;
        trig_in = 1'b1; cyc(5);
        chk("R3 edge trig", chan_state, 2);
        chk("R7 no ovr yet", flags[2], 0);
        trig_in = 1'b0; cyc(4);
        trig_in = 1'b1; cyc(5);
        chk("R7 overrun", flags[2], 1);
        chk("R10 irq ovr", irq, 3'b100);
        irq_en = 3'b000; #1;
        chk("R10 irq masked", irq, 3'b000);

        // R6 R7: level gate closes while triggered, reopens without overrun
        start(2'd3, 1'b0, 1'b1, 1'b0);
        irq_en = 3'b001;
        trig_in = 1'b1; cyc(5);
        chk("R6 triggered", chan_state, 2);
        trig_in = 1'b0; cmd_valid = 1'b1; cmd_word = 32'h0;
        cyc(2);
        chk("R6 no ready on closed gate", cmd_ready, 0);
        cyc(3); cmd_valid = 1'b0;
        chk("R6 gate close state", chan_state, 1);
        chk("R6 gate close pause", flags[0], 1);
        chk("R10 irq pause", irq, 3'b001);
        trig_in = 1'b1; cyc(5);
        chk("R6 reopened", chan_state, 2);
        trig_in = 1'b0; cyc(4); trig_in = 1'b1; cyc(5);
        chk("R7 level no overrun", flags[2], 0);
        irq_en = 3'b000;

        // R3: falling polarity
        start(2'd2, 1'b0, 1'b0, 1'b1);
        cyc(5);
        chk("R3 no trigger on rise", chan_state, 1);
        trig_in = 1'b0; cyc(5);
        chk("R3 falling edge trig", chan_state, 2);

        // R2: mode off keeps channel idle
        start(2'd0, 1'b1, 1'b1, 1'b0);
        cmd_valid = 1'b1; cyc(4);
        chk("R2 off idle", chan_state, 0);
        chk("R2 off no ready", cmd_ready, 0);
        cmd_valid = 1'b0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule